// File: doc/BRIEF.md
# Fairness-Interval Bus Arbiter with Urgent Class

This block is the central arbiter of a shared serial bus and sits at the root of the bus tree. Each attached node raises a request line when it has a packet to send. The arbiter grants the bus to one node at a time and holds that grant until the node strobes packet-done. Among competing nodes, the one with the lowest index wins, because a lower index means the node sits closer to the root.

To keep near-root nodes from starving the rest, time is split into fairness intervals, and each node carries an eligibility flag. A normal node loses its flag when it wins and cannot compete again in the same interval. A node configured as urgent keeps its flag, so it may win repeatedly. A credit counter limits this to three urgent packets for each normal packet while normal traffic is waiting.

A new interval starts when no requester is eligible and at least one flag has been spent. At that point every flag is set again, and the arbiter pulses an interval-start output for one cycle.

Top module: `fair_bus_arbiter`

## Requirements
- R1: While reset is asserted, and directly after it, the grant vector is all zeros and the interval-start output is low.
- R2: When several eligible nodes request at once, the grant goes to the eligible requester with the lowest index (bit 0 has the highest priority).
- R3: The grant is one-hot or zero. A grant that appears always names a node whose request was high in the cycle before.
- R4: A grant stays unchanged until done is sampled high, and it drops to zero in the cycle after that. The next grant comes no earlier than one further cycle later.
- R5: A node with its urgent bit low that has won the bus is not granted again until a new interval has started.
- R6: When no grant is held, no requester is eligible and some flag is spent, all flags are set again. The interval-start output is then high for exactly one cycle, during which no grant is held.
- R7: A node with its urgent bit high keeps its flag when it wins. It may be granted any number of times within one interval, and its wins never start a new interval.
- R8: The urgent credit starts at 3 and is restored to 3 at every interval start and every normal grant. Each urgent grant uses one credit. With no credit left, urgent requesters lose to any eligible normal requester, whatever their index.
- R9: With no credit left and no eligible normal request, an urgent requester is still granted.
- R10: With no request lines high and no grant held, the grant vector stays all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_NODES | Per-node request lines |
| urgent_i | input | N_NODES | Per-node urgent class bits |
| done_i | input | 1 | Packet-done strobe from the granted node |
| grant_o | output | N_NODES | One-hot grant, zero when the bus is free |
| interval_reset_o | output | 1 | One-cycle pulse when a new fairness interval begins |

## Verification
The bench models each node as a packet count that keeps its request high until the count is used up. Expected grant orders are worked out by hand and compared as grants appear.

The first pattern uses only normal nodes, one of which has two packets. It separates lowest-index priority from once-per-interval fairness, because the second packet must wait for an interval start.

The second pattern mixes one urgent node with two normal ones. It exposes the 3:1 credit split and the credit reload.

The third pattern uses a lone urgent node. It shows that an empty credit does not block urgent traffic when no normal request is waiting, and that urgent wins never start an interval. Counts of interval-start cycles and the timing around each done strobe are checked in every pattern.

// File: rtl/fba_pkg.sv
package fba_pkg;

   // Bits needed to hold the values 0..max_val
   function automatic int credit_width(input int max_val);
      int w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction

   localparam int DEFAULT_URGENT_RATIO = 3;

endpackage

// File: rtl/fba_eligible.sv
module fba_eligible #(
   parameter int N_NODES  = 4,
   parameter int CREDIT_W = 2
) (
   input  logic [N_NODES-1:0]  req,
   input  logic [N_NODES-1:0]  urgent,
   input  logic [N_NODES-1:0]  flag,
   input  logic [CREDIT_W-1:0] credit,
   output logic [N_NODES-1:0]  eligible
);

   logic [N_NODES-1:0] normal_ok;
   logic [N_NODES-1:0] urgent_req;
   logic               normal_waiting;
   logic               urgent_allowed;

   always_comb begin
      normal_ok      = req & ~urgent & flag;
      urgent_req     = req & urgent;
      normal_waiting = |normal_ok;
      urgent_allowed = (credit != '0) || !normal_waiting;
      eligible       = normal_ok | (urgent_allowed ? urgent_req : '0);
   end

endmodule

// File: rtl/fba_lowest_pick.sv
module fba_lowest_pick #(
   parameter int N_NODES = 4
) (
   input  logic [N_NODES-1:0] cand,
   output logic [N_NODES-1:0] pick
);

   logic [N_NODES-1:0] lower_taken;

   assign lower_taken[0] = 1'b0;
   assign pick[0]        = cand[0];

   for (genvar i = 1; i < N_NODES; i++) begin : g_chain
      assign lower_taken[i] = lower_taken[i-1] | cand[i-1];
      assign pick[i]        = cand[i] & ~lower_taken[i];
   end

endmodule

// File: rtl/fba_credit.sv
module fba_credit #(
   parameter int RATIO    = 3,
   parameter int CREDIT_W = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reload,
   input  logic                spend,
   output logic [CREDIT_W-1:0] credit
);

   localparam logic [CREDIT_W-1:0] FULL = CREDIT_W'(RATIO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         credit <= FULL;
      end else if (reload) begin
         credit <= FULL;
      end else if (spend && credit != '0) begin
         credit <= credit - 1'b1;
      end
   end

endmodule

// File: rtl/fair_bus_arbiter.sv
module fair_bus_arbiter #(
   parameter int N_NODES      = 4,
   parameter int URGENT_RATIO = fba_pkg::DEFAULT_URGENT_RATIO
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_NODES-1:0] req_i,
   input  logic [N_NODES-1:0] urgent_i,
   input  logic               done_i,
   output logic [N_NODES-1:0] grant_o,
   output logic               interval_reset_o
);

   localparam int CREDIT_W = fba_pkg::credit_width(URGENT_RATIO);

   if (N_NODES < 2) begin : g_bad_nodes
      $error("fair_bus_arbiter: N_NODES must be at least 2");
   end
   if (URGENT_RATIO < 1) begin : g_bad_ratio
      $error("fair_bus_arbiter: URGENT_RATIO must be at least 1");
   end

   logic [N_NODES-1:0]  grant_q;
   logic [N_NODES-1:0]  flag_q;
   logic [N_NODES-1:0]  eligible;
   logic [N_NODES-1:0]  winner;
   logic [CREDIT_W-1:0] credit;
   logic                ireset_q;
   logic                bus_free;
   logic                start_interval;
   logic                win_urgent;
   logic                win_normal;

   fba_eligible #(.N_NODES(N_NODES), .CREDIT_W(CREDIT_W)) u_elig (
      .req      (req_i),
      .urgent   (urgent_i),
      .flag     (flag_q),
      .credit   (credit),
      .eligible (eligible)
   );

   fba_lowest_pick #(.N_NODES(N_NODES)) u_pick (
      .cand (eligible),
      .pick (winner)
   );

   always_comb begin
      bus_free       = (grant_q == '0);
      start_interval = bus_free && (eligible == '0) && !(&flag_q);
      win_urgent     = bus_free && |(winner & urgent_i);
      win_normal     = bus_free && |(winner & ~urgent_i);
   end

   fba_credit #(.RATIO(URGENT_RATIO), .CREDIT_W(CREDIT_W)) u_credit (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (start_interval || win_normal),
      .spend  (win_urgent),
      .credit (credit)
   );

   // Per-node eligibility flags: set at interval start, cleared on a normal win
   for (genvar i = 0; i < N_NODES; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[i] <= 1'b1;
         end else if (start_interval) begin
            flag_q[i] <= 1'b1;
         end else if (bus_free && winner[i] && !urgent_i[i]) begin
            flag_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q  <= '0;
         ireset_q <= 1'b0;
      end else begin
         ireset_q <= start_interval;
         if (bus_free) begin
            grant_q <= winner;
         end else if (done_i) begin
            grant_q <= '0;
         end
      end
   end

   assign grant_o          = grant_q;
   assign interval_reset_o = ireset_q;

endmodule

// File: rtl/fba_checker.sv
module fba_checker #(
   parameter int N_NODES = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_NODES-1:0] req_i,
   input logic [N_NODES-1:0] urgent_i,
   input logic               done_i,
   input logic [N_NODES-1:0] grant_o,
   input logic               interval_reset_o
);

   logic unused_urgent;
   assign unused_urgent = |urgent_i;

   p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   p_grant_to_requester_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o == '0) |=> ((grant_o == '0) || ((grant_o & $past(req_i)) != '0)));

   p_hold_until_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant_o != '0) && !done_i) |=> $stable(grant_o));

   p_release_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant_o != '0) && done_i) |=> (grant_o == '0));

   p_interval_bus_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
      interval_reset_o |-> (grant_o == '0));

   p_interval_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      interval_reset_o |=> !interval_reset_o);

   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_i == '0) && (grant_o == '0)) |=> (grant_o == '0));

endmodule

bind fair_bus_arbiter fba_checker #(.N_NODES(N_NODES)) u_fba_checker (.*);

// File: tb/fair_bus_arbiter_bench.sv
`timescale 1ns/100ps
module fair_bus_arbiter_bench;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [N-1:0] req_i;
   logic [N-1:0] urgent_i;
   logic         done_i;
   logic [N-1:0] grant_o;
   logic         interval_reset_o;

   int pkts [N];
   int exp_q [$];
   int n_checks = 0;
   int n_errs   = 0;
   int ireset_cycles = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) req_i[i] = (pkts[i] > 0);
   end

   fair_bus_arbiter #(.N_NODES(N)) u_fair_bus_arbiter (
      .clk              (clk),
      .rst_n            (rst_n),
      .req_i            (req_i),
      .urgent_i         (urgent_i),
      .done_i           (done_i),
      .grant_o          (grant_o),
      .interval_reset_o (interval_reset_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int index_of(input logic [N-1:0] g);
      for (int i = 0; i < N; i++) if (g[i]) return i;
      return -1;
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   endtask

   task automatic drain();
      bool_wait: while (exp_q.size() != 0 || req_i != '0 || grant_o != '0)
         @(negedge clk);
      repeat (8) @(negedge clk);
   endtask

   initial begin
      rst_n    = 1'b0;
      done_i   = 1'b0;
      urgent_i = '0;
      for (int i = 0; i < N; i++) pkts[i] = 0;

      fork
         // Watchdog
         begin
            repeat (100000) @(posedge clk);
            check(1'b0, "watchdog expired", 0, 1);
            finish_run();
         end
         // Monitor: scoreboard comparison on each new grant
         begin
            logic [N-1:0] prev;
            prev = '0;
            forever begin
               @(negedge clk);
               if (rst_n) begin
                  if (interval_reset_o) ireset_cycles++;
                  if (grant_o != '0 && prev == '0) begin
                     check($countones(grant_o) == 1, "R3 grant one-hot", $countones(grant_o), 1);
                     if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected grant", index_of(grant_o), -1);
                     end else begin
                        int e;
                        e = exp_q.pop_front();
                        check(index_of(grant_o) == e, "R2/R5/R8 grant order", index_of(grant_o), e);
                     end
                  end
                  prev = grant_o;
               end
            end
         end
         // Responder: models the granted node finishing its packet
         begin
            forever begin
               @(negedge clk);
               if (rst_n && grant_o != '0) begin
                  logic [N-1:0] g;
                  int idx;
                  g   = grant_o;
                  idx = index_of(g);
                  repeat (2) begin
                     @(negedge clk);
                     check(grant_o == g, "R4 grant held", int'(grant_o), int'(g));
                  end
                  done_i = 1'b1;
                  if (idx >= 0 && pkts[idx] > 0) pkts[idx] = pkts[idx] - 1;
                  @(negedge clk);
                  done_i = 1'b0;
                  check(grant_o == '0, "R4 release after done", int'(grant_o), 0);
               end
            end
         end
      join_none

      // R1: reset state
      repeat (3) @(negedge clk);
      check(grant_o == '0, "R1 grant in reset", int'(grant_o), 0);
      check(interval_reset_o == 1'b0, "R1 interval in reset", int'(interval_reset_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(grant_o == '0, "R1 grant after reset", int'(grant_o), 0);
      check(interval_reset_o == 1'b0, "R1 interval after reset", int'(interval_reset_o), 0);

      // R10: idle bus stays ungranted
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         check(grant_o == '0, "R10 idle grant", int'(grant_o), 0);
      end
      check(ireset_cycles == 0, "R6 no interval start while all flags set", ireset_cycles, 0);

      // Scenario A (R2, R5, R6): normal nodes only; node 0 holds two packets
      ireset_cycles = 0;
      urgent_i = '0;
      exp_q = '{0, 1, 2, 0};
      pkts[0] = 2; pkts[1] = 1; pkts[2] = 1;
      drain();
      check(ireset_cycles == 2, "R6 interval starts in scenario A", ireset_cycles, 2);

      // Scenario B (R7, R8): node 1 urgent with 5 packets, nodes 2 and 3 normal
      ireset_cycles = 0;
      urgent_i = 4'b0010;
      exp_q = '{1, 1, 1, 2, 1, 1, 3, 2};
      pkts[1] = 5; pkts[2] = 2; pkts[3] = 1;
      drain();
      check(ireset_cycles == 2, "R8 interval starts in scenario B", ireset_cycles, 2);

      // Scenario C (R7, R9): lone urgent node keeps winning past an empty credit
      ireset_cycles = 0;
      urgent_i = 4'b0001;
      exp_q = '{0, 0, 0, 0, 0};
      pkts[0] = 5;
      drain();
      check(ireset_cycles == 0, "R7 urgent wins start no interval", ireset_cycles, 0);
      check(exp_q.size() == 0, "R9 all urgent grants seen", exp_q.size(), 0);

      // R10 again after traffic
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         check(grant_o == '0, "R10 idle grant after traffic", int'(grant_o), 0);
      end

      finish_run();
   end

endmodule